// File: doc/BRIEF.md
# RTC Host Register Interface and Interrupt Logic

This block is the host-facing side of a real-time clock. The host reaches a 64-byte register space in two steps. It first writes a register number to an index port. It then reads or writes a data port, and that access goes to the stored index. The space holds ten time and alarm bytes, four control and status bytes, and 50 bytes of general-purpose RAM that is meant to keep its contents while the clock is battery-backed.

The timekeeping counter and the periodic divider live outside the block. They send in single-cycle pulses for the update-end, alarm and periodic events, and they read back the divider, rate and mode controls held here. Each event latches its own flag whether or not it is enabled. The flag raises the interrupt output only when its enable bit is also set. A host read of the status byte returns the flags and clears all of them in the same access.

Host requests use a valid/ready handshake. A request is taken on a clock edge where `bus_valid` and `bus_ready` are both high. Only one read can be outstanding. While a read response is waiting, `bus_ready` stays low, and `rsp_data` holds still until the host takes the response with `rsp_ready`.

Top module: `rtc_regif`

## Requirements
- R1: After reset, the following are all low or zero: `irq`, `rsp_valid`, the index, every control output and every latched flag. `bus_ready` is high after reset.
- R2: `bus_op` selects the access type: 0 writes the index, 1 writes data and 2 reads data; the value 3 is ignored. Bytes 0..9 and 14..63 store written data and return it on a later read.
- R3: Only the low 6 bits of an index write are kept, so the index wraps modulo 64.
- R4: Byte 10 holds two host-writable fields. Bits 3:0 drive `rate_sel` and bits 6:4 drive `div_sel`. Bit 7 reads as `uip_in`, and host writes to bit 7 are ignored.
- R5: Byte 11 holds eight writable bits, from bit 0 up: `dst_en`, `hour24`, `bin_mode`, `sqw_en`, update-end enable, alarm enable, periodic enable and `set_hold`. It reads back what was written.
- R6: Bytes 12 and 13 ignore host writes. Byte 13 reads as `{vrt_in, 7'b0}`.
- R7: An event pulse sets its flag whatever the enable bits are. Byte 12 carries the update-end flag in bit 4, the alarm flag in bit 5 and the periodic flag in bit 6. Bits 3:0 of byte 12 read as 0.
- R8: Bit 7 of byte 12 and the `irq` output are high whenever some flag and its matching enable bit in byte 11 are both set. Setting the enable after the flag also raises `irq`.
- R9: A read of byte 12 returns the flags as they stood before the read, then clears all of them.
- R10: An event that arrives in the same cycle as a clearing read of byte 12 is kept.
- R11: While a response is pending, `bus_ready` is low, and `rsp_valid` and `rsp_data` stay stable until `rsp_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host request valid |
| bus_ready | output | 1 | Block can accept a request |
| bus_op | input | 2 | 0 write index, 1 write data, 2 read data |
| bus_wdata | input | 8 | Index or data byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host accepts response |
| rsp_data | output | 8 | Read response byte |
| ev_update_end | input | 1 | Update-end event pulse |
| ev_alarm | input | 1 | Alarm match event pulse |
| ev_periodic | input | 1 | Periodic tick event pulse |
| uip_in | input | 1 | Update-in-progress from the counter |
| vrt_in | input | 1 | Valid RAM and time indicator |
| irq | output | 1 | Interrupt request, active high |
| rate_sel | output | 4 | Periodic rate select |
| div_sel | output | 3 | Time-base divider select |
| dst_en | output | 1 | Daylight-saving enable |
| hour24 | output | 1 | 24-hour mode |
| bin_mode | output | 1 | Binary (not BCD) mode |
| sqw_en | output | 1 | Square-wave output enable |
| set_hold | output | 1 | Updates held while time is set |

## Verification
Most internal faults surface at `irq` within one cycle. A flag that sticks, drops or lands in the wrong bit shows at `irq` on the cycle after its event or enable write. It also shows as a wrong byte on the next status read. An index or decode fault shows as a wrong byte in the response that follows. A fault in the clear path, where it meets a coincident event, shows only on the second status read after the event.

// File: rtl/rtc_regif_pkg.sv
package rtc_regif_pkg;

  localparam int BYTE_W     = 8;
  localparam int TOD_REGS   = 10;
  localparam int IDX_CTL_A  = TOD_REGS;
  localparam int IDX_CTL_B  = TOD_REGS + 1;
  localparam int IDX_STATUS = TOD_REGS + 2;
  localparam int IDX_VALID  = TOD_REGS + 3;
  localparam int RAM_BASE   = TOD_REGS + 4;
  localparam int N_EVENTS   = 3;

  // bit positions inside control byte B
  localparam int B_DSE  = 0;
  localparam int B_HR24 = 1;
  localparam int B_BIN  = 2;
  localparam int B_SQW  = 3;
  localparam int B_EN0  = 4;   // enables occupy B_EN0 .. B_EN0+N_EVENTS-1
  localparam int B_SET  = 7;

  // status byte: flags start at FLAG_LSB, summary at bit 7
  localparam int FLAG_LSB = 4;

  typedef enum logic [1:0] {
    OP_SET_INDEX = 2'd0,
    OP_WRITE     = 2'd1,
    OP_READ      = 2'd2,
    OP_IGNORE    = 2'd3
  } bus_op_e;

endpackage

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import rtc_regif_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [1:0]        bus_op,
  input  logic [IDX_W-1:0]  idx_wdata,
  output logic              bus_ready,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  input  logic [BYTE_W-1:0] rd_value,
  output logic [IDX_W-1:0]  idx_q,
  output logic              wr_fire,
  output logic              rd_fire
);

  logic fire;

  assign bus_ready = !rsp_valid;
  assign fire      = bus_valid && bus_ready;
  assign wr_fire   = fire && (bus_op == OP_WRITE);
  assign rd_fire   = fire && (bus_op == OP_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (fire && (bus_op == OP_SET_INDEX)) begin
      idx_q <= idx_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags
  import rtc_regif_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_EVENTS-1:0] ev,
  input  logic [N_EVENTS-1:0] en,
  input  logic                clr,
  output logic [N_EVENTS-1:0] flags_q,
  output logic                irq
);

  logic [N_EVENTS-1:0] flags_d;

  // a clearing read drops old flags; events in the same cycle survive
  assign flags_d = (clr ? '0 : flags_q) | ev;
  assign irq     = |(flags_q & en);

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regif_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    idx,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                uip_in,
  input  logic                vrt_in,
  input  logic                irq_sum,
  input  logic [N_EVENTS-1:0] flags,
  output logic [BYTE_W-1:0]   rd_value,
  output logic [BYTE_W-2:0]   ctl_a_q,
  output logic [BYTE_W-1:0]   ctl_b_q
);

  localparam int RAM_DEPTH = (1 << IDX_W) - RAM_BASE;
  localparam int RAM_AW    = $clog2(RAM_DEPTH);
  localparam int TOD_AW    = $clog2(TOD_REGS);

  logic [BYTE_W-1:0] tod_q [TOD_REGS];
  logic [BYTE_W-1:0] ram_q [RAM_DEPTH];

  logic              is_tod, is_ram, is_a, is_b, is_status, is_valid;
  logic [TOD_AW-1:0] tod_ix;
  logic [RAM_AW-1:0] ram_ix;
  logic [BYTE_W-1:0] status_byte;

  assign is_tod    = idx <  IDX_W'(TOD_REGS);
  assign is_ram    = idx >= IDX_W'(RAM_BASE);
  assign is_a      = idx == IDX_W'(IDX_CTL_A);
  assign is_b      = idx == IDX_W'(IDX_CTL_B);
  assign is_status = idx == IDX_W'(IDX_STATUS);
  assign is_valid  = idx == IDX_W'(IDX_VALID);
  assign tod_ix    = idx[TOD_AW-1:0];
  assign ram_ix    = RAM_AW'(idx - IDX_W'(RAM_BASE));

  always_comb begin
    status_byte = '0;
    status_byte[BYTE_W-1] = irq_sum;
    for (int k = 0; k < N_EVENTS; k++) status_byte[FLAG_LSB + k] = flags[k];
  end

  // storage without reset: contents are expected to outlive a reset
  always_ff @(posedge clk) begin
    if (wr_en && is_tod) tod_q[tod_ix] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (wr_en && is_ram) ram_q[ram_ix] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_a_q <= '0;
      ctl_b_q <= '0;
    end else if (wr_en) begin
      if (is_a) ctl_a_q <= wdata[BYTE_W-2:0];
      if (is_b) ctl_b_q <= wdata;
    end
  end

  always_comb begin
    rd_value = '0;
    if (is_tod)         rd_value = tod_q[tod_ix];
    else if (is_a)      rd_value = {uip_in, ctl_a_q};
    else if (is_b)      rd_value = ctl_b_q;
    else if (is_status) rd_value = status_byte;
    else if (is_valid)  rd_value = {vrt_in, {(BYTE_W-1){1'b0}}};
    else if (is_ram)    rd_value = ram_q[ram_ix];
  end

endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
  import rtc_regif_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  output logic        bus_ready,
  input  logic [1:0]  bus_op,
  input  logic [7:0]  bus_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [7:0]  rsp_data,
  input  logic        ev_update_end,
  input  logic        ev_alarm,
  input  logic        ev_periodic,
  input  logic        uip_in,
  input  logic        vrt_in,
  output logic        irq,
  output logic [3:0]  rate_sel,
  output logic [2:0]  div_sel,
  output logic        dst_en,
  output logic        hour24,
  output logic        bin_mode,
  output logic        sqw_en,
  output logic        set_hold
);

  logic [IDX_W-1:0]    idx_q;
  logic                wr_fire, rd_fire, clr_status;
  logic [BYTE_W-1:0]   rd_value;
  logic [BYTE_W-2:0]   ctl_a_q;
  logic [BYTE_W-1:0]   ctl_b_q;
  logic [N_EVENTS-1:0] ev_vec, en_vec, flags_q;

  assign ev_vec     = {ev_periodic, ev_alarm, ev_update_end};
  assign en_vec     = ctl_b_q[B_EN0 +: N_EVENTS];
  assign clr_status = rd_fire && (idx_q == IDX_W'(IDX_STATUS));

  rtc_host_port #(.IDX_W(IDX_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_op    (bus_op),
    .idx_wdata (bus_wdata[IDX_W-1:0]),
    .bus_ready (bus_ready),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rd_value  (rd_value),
    .idx_q     (idx_q),
    .wr_fire   (wr_fire),
    .rd_fire   (rd_fire)
  );

  rtc_event_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev_vec),
    .en      (en_vec),
    .clr     (clr_status),
    .flags_q (flags_q),
    .irq     (irq)
  );

  rtc_regfile #(.IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fire),
    .idx      (idx_q),
    .wdata    (bus_wdata),
    .uip_in   (uip_in),
    .vrt_in   (vrt_in),
    .irq_sum  (irq),
    .flags    (flags_q),
    .rd_value (rd_value),
    .ctl_a_q  (ctl_a_q),
    .ctl_b_q  (ctl_b_q)
  );

  assign rate_sel = ctl_a_q[3:0];
  assign div_sel  = ctl_a_q[6:4];
  assign dst_en   = ctl_b_q[B_DSE];
  assign hour24   = ctl_b_q[B_HR24];
  assign bin_mode = ctl_b_q[B_BIN];
  assign sqw_en   = ctl_b_q[B_SQW];
  assign set_hold = ctl_b_q[B_SET];

endmodule

// File: rtl/rtc_regif_chk.sv
module rtc_regif_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [7:0]       rsp_data,
  input logic             irq,
  input logic             ev_update_end,
  input logic             ev_alarm,
  input logic             ev_periodic,
  input logic [2:0]       flags,
  input logic [2:0]       en,
  input logic             wr_fire,
  input logic             rd_fire,
  input logic [IDX_W-1:0] idx
);

  logic ev_any;
  assign ev_any = ev_update_end || ev_alarm || ev_periodic;

  p_ready_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_ready);

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_event_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alarm |=> flags[1]);

  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en != 3'b000) && (flags != 3'b000));

  p_status_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && idx == IDX_W'(12) && !ev_any) |=> (flags == 3'b000));

  p_status_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && idx == IDX_W'(12) && !ev_any && !rd_fire) |=> $stable(flags));

  p_coincident_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && ev_update_end) |=> flags[0]);

endmodule

bind rtc_regif rtc_regif_chk #(.IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_ready     (bus_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .irq           (irq),
  .ev_update_end (ev_update_end),
  .ev_alarm      (ev_alarm),
  .ev_periodic   (ev_periodic),
  .flags         (flags_q),
  .en            (en_vec),
  .wr_fire       (wr_fire),
  .rd_fire       (rd_fire),
  .idx           (idx_q)
);

// File: tb/rtc_regif_tb.sv
module rtc_regif_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0;
  logic       bus_ready;
  logic [1:0] bus_op = 2'd3;
  logic [7:0] bus_wdata = 8'h00;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       ev_update_end = 1'b0, ev_alarm = 1'b0, ev_periodic = 1'b0;
  logic       uip_in = 1'b0, vrt_in = 1'b0;
  logic       irq;
  logic [3:0] rate_sel;
  logic [2:0] div_sel;
  logic       dst_en, hour24, bin_mode, sqw_en, set_hold;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  rtc_regif u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_op(bus_op), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .ev_update_end(ev_update_end),
    .ev_alarm(ev_alarm), .ev_periodic(ev_periodic), .uip_in(uip_in),
    .vrt_in(vrt_in), .irq(irq), .rate_sel(rate_sel), .div_sel(div_sel),
    .dst_en(dst_en), .hour24(hour24), .bin_mode(bin_mode), .sqw_en(sqw_en),
    .set_hold(set_hold)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a response is taken
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected response", {24'h0, rsp_data}, 32'hFFFF_FFFF);
      end else begin
        check(tag_q.pop_front(), {24'h0, rsp_data}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic bus_txn(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    while (!bus_ready) @(negedge clk);
    bus_valid = 1'b1; bus_op = op; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_op = 2'd3;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
    bus_txn(2'd0, idx);
    bus_txn(2'd1, d);
  endtask

  task automatic rd_reg(input logic [7:0] idx, input logic [7:0] exp, input string req);
    bus_txn(2'd0, idx);
    exp_q.push_back(exp); tag_q.push_back(req);
    bus_txn(2'd2, 8'h00);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_update_end = 1'b1;
      1: ev_alarm = 1'b1;
      default: ev_periodic = 1'b1;
    endcase
    @(negedge clk);
    ev_update_end = 1'b0; ev_alarm = 1'b0; ev_periodic = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) @(negedge clk);
    check("R11 scoreboard empty", exp_q.size(), 0);
  endtask

  initial begin
    #(200000 * 10);
    check("watchdog expired", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 bus_ready", bus_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 controls", {rate_sel, div_sel, dst_en, hour24, bin_mode, sqw_en, set_hold}, 0);
    rd_reg(8'd12, 8'h00, "R1 flags clear");

    // R2 storage in time and RAM bytes, ignored op value
    wr_reg(8'd14, 8'hA5);
    wr_reg(8'd63, 8'h3C);
    wr_reg(8'd0,  8'h59);
    wr_reg(8'd9,  8'h99);
    bus_txn(2'd0, 8'd14);
    bus_txn(2'd3, 8'h11);
    rd_reg(8'd14, 8'hA5, "R2 ram low / op3 ignored");
    rd_reg(8'd63, 8'h3C, "R2 ram top");
    rd_reg(8'd0,  8'h59, "R2 seconds");
    rd_reg(8'd9,  8'h99, "R2 year");
    // R3 index wraps modulo 64
    rd_reg(8'd78, 8'hA5, "R3 index wrap");

    // R4 control A
    wr_reg(8'd10, 8'hFF);
    rd_reg(8'd10, 8'h7F, "R4 bit7 write ignored");
    @(negedge clk);
    check("R4 rate_sel", rate_sel, 4'hF);
    check("R4 div_sel", div_sel, 3'h7);
    uip_in = 1'b1;
    rd_reg(8'd10, 8'hFF, "R4 uip visible");
    uip_in = 1'b0;
    wr_reg(8'd10, 8'h26);
    @(negedge clk);
    check("R4 rate/div", {div_sel, rate_sel}, {3'h2, 4'h6});

    // R5 control B
    wr_reg(8'd11, 8'h8F);
    @(negedge clk);
    check("R5 mode outputs", {set_hold, sqw_en, bin_mode, hour24, dst_en}, 5'b11111);
    rd_reg(8'd11, 8'h8F, "R5 readback");
    wr_reg(8'd11, 8'h04);
    @(negedge clk);
    check("R5 bin only", {set_hold, sqw_en, bin_mode, hour24, dst_en}, 5'b00100);
    wr_reg(8'd11, 8'h00);

    // R6 status and valid bytes are read-only
    wr_reg(8'd12, 8'hFF);
    rd_reg(8'd12, 8'h00, "R6 status write ignored");
    wr_reg(8'd13, 8'hFF);
    vrt_in = 1'b1;
    rd_reg(8'd13, 8'h80, "R6 valid bit");
    vrt_in = 1'b0;
    rd_reg(8'd13, 8'h00, "R6 valid clear");

    // R7 flags latch without enables, irq stays low
    pulse(0); pulse(1); pulse(2);
    check("R7 irq without enable", irq, 0);
    rd_reg(8'd12, 8'h70, "R7 all flags");
    rd_reg(8'd12, 8'h00, "R9 cleared by read");

    // R8 alarm enabled
    wr_reg(8'd11, 8'h20);
    pulse(2);
    check("R8 periodic not enabled", irq, 0);
    pulse(1);
    check("R8 alarm raises irq", irq, 1);
    rd_reg(8'd12, 8'hE0, "R8 summary bit");
    @(negedge clk);
    check("R9 irq after clear", irq, 0);
    // R8 enable after flag
    pulse(2);
    check("R8 flag before enable", irq, 0);
    wr_reg(8'd11, 8'h40);
    @(negedge clk);
    check("R8 late enable", irq, 1);
    rd_reg(8'd12, 8'hC0, "R8 periodic summary");

    // R10 event coincident with clearing read
    wr_reg(8'd11, 8'h10);
    pulse(0);
    check("R8 update-end irq", irq, 1);
    bus_txn(2'd0, 8'd12);
    @(negedge clk);
    while (!bus_ready) @(negedge clk);
    bus_valid = 1'b1; bus_op = 2'd2; ev_alarm = 1'b1;
    exp_q.push_back(8'h90); tag_q.push_back("R10 read before coincident event");
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_op = 2'd3; ev_alarm = 1'b0;
    @(negedge clk);
    check("R10 irq low, alarm disabled", irq, 0);
    rd_reg(8'd12, 8'h20, "R10 coincident event kept");

    // R11 back-pressure
    drain();
    rsp_ready = 1'b0;
    rd_reg(8'd14, 8'hA5, "R11 held response");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11 rsp_valid held", rsp_valid, 1);
      check("R11 bus_ready low", bus_ready, 0);
      check("R11 data held", rsp_data, 8'hA5);
    end
    rsp_ready = 1'b1;
    drain();
    rd_reg(8'd63, 8'h3C, "R11 next read after release");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule